// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps the coherence state of a small direct-mapped cache that sits on a shared, snooped bus. Every line holds a tag, one data word and a two-bit state: Invalid, Shared, Exclusive or Modified. The internal encoding is I=00, S=01, E=10, M=11. The controller serves two sources of work. The first is the local CPU, which issues reads and writes. The second is the bus, on which the transactions of the other caches are snooped. A CPU access that the line's state cannot satisfy locally becomes a bus request. Snooped transactions that hit a held line make the controller supply data, drive the shared response, write back dirty data or drop the line.

The CPU raises `cpu_req_i` and holds the request until `cpu_ready_o` pulses. A bus request stays raised until `bus_gnt_i`. The whole transaction completes in the grant cycle: memory or another cache presents `bus_data_i`, and the other caches drive `bus_shared_i`. Bus commands are coded none=00, read=01, read-for-ownership=10 and invalidate=11, on both `bus_cmd_o` and `snp_cmd_i`. The snoop responses are combinational in the cycle of `snp_valid_i`. Write-backs come out one cycle later as a single-cycle pulse on `wb_valid_o`. A snoop never arrives in the same cycle as this cache's own grant. A CPU request is not accepted in a cycle that carries a snoop.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, so a snoop of any address gets no shared, no supply and no write-back response.
- R2: A read miss issues a bus read (01). The line is filled with `bus_data_i` and ends in Exclusive if `bus_shared_i` was low at the grant, or in Shared if it was high. The filled word is returned on `cpu_rdata_o`.
- R3: A snooped read (01) that hits a line in Exclusive or Shared raises `snp_shared_o` and `snp_supply_o`, drives the line data on `snp_data_o`, leaves the line in Shared and produces no write-back.
- R4: A snooped read that hits a Modified line does the same as R3 and also writes the line back: `wb_valid_o` with the line address and data in the following cycle.
- R5: A CPU write to a Shared line issues an invalidate (11). On the grant, the line takes the write data and becomes Modified.
- R6: A CPU write to an Exclusive line raises no bus request and makes the line Modified.
- R7: A snooped invalidate (11) or read-for-ownership (10) that hits a line makes it Invalid. A read-for-ownership also supplies the data but does not raise `snp_shared_o`.
- R8: A snooped invalidate or read-for-ownership that hits a Modified line writes the data back in the following cycle.
- R9: A CPU write to a Modified line completes with no bus request and no write-back.
- R10: A write miss issues one read-for-ownership (10). The line ends Modified and holds the write data.
- R11: The command for a pending request is chosen from the line state at grant time. A write that was waiting to invalidate a Shared line switches to read-for-ownership if a snoop invalidated the line meanwhile.
- R12: A miss whose victim line is Modified writes the victim back (its own tag and index) one cycle after acceptance. While not granted, `bus_req_o` and `bus_addr_o` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU request, held until ready |
| cpu_we_i | input | 1 | CPU write when high |
| cpu_addr_i | input | ADDR_W | CPU word address |
| cpu_wdata_i | input | DATA_W | CPU write data |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read data, valid with ready |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant; the transaction completes this cycle |
| bus_cmd_o | output | 2 | Command of own transaction |
| bus_addr_o | output | ADDR_W | Address of own transaction |
| bus_data_i | input | DATA_W | Fill data during grant |
| bus_shared_i | input | 1 | Another cache holds the line |
| snp_valid_i | input | 1 | Snooped transaction present |
| snp_cmd_i | input | 2 | Snooped command |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_shared_o | output | 1 | Shared response to a snooped read |
| snp_supply_o | output | 1 | This cache supplies data |
| snp_data_o | output | DATA_W | Supplied data |
| wb_valid_o | output | 1 | Write-back to memory |
| wb_addr_o | output | ADDR_W | Write-back address |
| wb_data_o | output | DATA_W | Write-back data |

## Verification
The bench walks one line through every state and hits it with each snoop type. It checks that a Modified line is written back on a snooped read and on a snooped invalidate. A design that skips the write-back would lose the only valid copy. It also checks that writes to Exclusive and Modified lines stay off the bus, where a wrong design would waste a bus transaction or write back early. The hardest case is a write that waits to invalidate a Shared line while a snoop kills that line. A design that latched the command at acceptance would send an invalidate for data it no longer holds, and the line would end Modified with a stale word. Evicting a dirty victim on a miss is checked for the victim's own address, not the requester's.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_RDX  = 2'b10,
    CMD_INV  = 2'b11
  } bus_cmd_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int N_LINES = 4,
  parameter int IDX_W   = 2,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           fill_we_i,
  input  logic [IDX_W-1:0]               fill_idx_i,
  input  mesi_e                          fill_st_i,
  input  logic [TAG_W-1:0]               fill_tag_i,
  input  logic [DATA_W-1:0]              fill_data_i,
  input  logic                           snp_we_i,
  input  logic [IDX_W-1:0]               snp_idx_i,
  input  mesi_e                          snp_st_i,
  output mesi_e [N_LINES-1:0]            st_o,
  output logic  [N_LINES-1:0][TAG_W-1:0] tag_o,
  output logic  [N_LINES-1:0][DATA_W-1:0] data_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_o[g]   <= ST_I;
        tag_o[g]  <= '0;
        data_o[g] <= '0;
      end else if (fill_we_i && fill_idx_i == IDX_W'(g)) begin
        st_o[g]   <= fill_st_i;
        tag_o[g]  <= fill_tag_i;
        data_o[g] <= fill_data_i;
      end else if (snp_we_i && snp_idx_i == IDX_W'(g)) begin
        st_o[g]   <= snp_st_i;
      end
    end
  end
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int N_LINES = 4,
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = 2,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            snp_valid_i,
  input  bus_cmd_e                        snp_cmd_i,
  input  logic [ADDR_W-1:0]               snp_addr_i,
  input  mesi_e [N_LINES-1:0]             st_i,
  input  logic  [N_LINES-1:0][TAG_W-1:0]  tag_i,
  input  logic  [N_LINES-1:0][DATA_W-1:0] data_i,
  output logic                            shared_o,
  output logic                            supply_o,
  output logic [DATA_W-1:0]               data_o,
  output logic                            st_we_o,
  output logic [IDX_W-1:0]                st_idx_o,
  output mesi_e                           st_new_o,
  output logic                            wb_o,
  output logic [ADDR_W-1:0]               wb_addr_o,
  output logic [DATA_W-1:0]               wb_data_o
);
  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;
  logic             s_hit;

  assign s_idx = snp_addr_i[IDX_W-1:0];
  assign s_tag = snp_addr_i[ADDR_W-1:IDX_W];
  assign s_hit = snp_valid_i && snp_cmd_i != CMD_NONE &&
                 st_i[s_idx] != ST_I && tag_i[s_idx] == s_tag;

  assign shared_o  = s_hit && snp_cmd_i == CMD_RD;
  assign supply_o  = s_hit && (snp_cmd_i == CMD_RD || snp_cmd_i == CMD_RDX);
  assign data_o    = supply_o ? data_i[s_idx] : '0;
  assign st_we_o   = s_hit;
  assign st_idx_o  = s_idx;
  assign st_new_o  = (snp_cmd_i == CMD_RD) ? ST_S : ST_I;
  assign wb_o      = s_hit && st_i[s_idx] == ST_M;
  assign wb_addr_o = snp_addr_i;
  assign wb_data_o = data_i[s_idx];

  // R3/R4: a snooped read leaves the line Shared
  a_r3_snoop_rd_shared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_hit && snp_cmd_i == CMD_RD |=> st_i[$past(s_idx)] == ST_S);
  // R7: invalidate or read-for-ownership kills the line
  a_r7_snoop_kill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_hit && snp_cmd_i != CMD_RD |=> st_i[$past(s_idx)] == ST_I);
endmodule

// File: rtl/mesi_cpu_fsm.sv
module mesi_cpu_fsm
  import mesi_pkg::*;
#(
  parameter int N_LINES = 4,
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = 2,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cpu_req_i,
  input  logic                            cpu_we_i,
  input  logic [ADDR_W-1:0]               cpu_addr_i,
  input  logic [DATA_W-1:0]               cpu_wdata_i,
  input  logic                            snp_valid_i,
  input  logic                            bus_gnt_i,
  input  logic                            bus_shared_i,
  input  logic [DATA_W-1:0]               bus_data_i,
  input  mesi_e [N_LINES-1:0]             st_i,
  input  logic  [N_LINES-1:0][TAG_W-1:0]  tag_i,
  input  logic  [N_LINES-1:0][DATA_W-1:0] data_i,
  input  logic                            snp_wb_i,
  input  logic [ADDR_W-1:0]               snp_wb_addr_i,
  input  logic [DATA_W-1:0]               snp_wb_data_i,
  output logic                            cpu_ready_o,
  output logic [DATA_W-1:0]               cpu_rdata_o,
  output logic                            bus_req_o,
  output bus_cmd_e                        bus_cmd_o,
  output logic [ADDR_W-1:0]               bus_addr_o,
  output logic                            wb_valid_o,
  output logic [ADDR_W-1:0]               wb_addr_o,
  output logic [DATA_W-1:0]               wb_data_o,
  output logic                            fill_we_o,
  output logic [IDX_W-1:0]                fill_idx_o,
  output mesi_e                           fill_st_o,
  output logic [TAG_W-1:0]                fill_tag_o,
  output logic [DATA_W-1:0]               fill_data_o
);
  typedef enum logic {FS_IDLE, FS_REQ} fsm_e;

  fsm_e              state_q;
  logic              we_q, ready_q, wb_q;
  logic [ADDR_W-1:0] addr_q, wb_addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, wb_data_q;

  logic [IDX_W-1:0]  c_idx, r_idx;
  logic [TAG_W-1:0]  c_tag, r_tag;
  mesi_e             c_st;
  logic              c_hit, r_hit, accept, done, local_ok, evict;

  assign c_idx  = cpu_addr_i[IDX_W-1:0];
  assign c_tag  = cpu_addr_i[ADDR_W-1:IDX_W];
  assign c_st   = st_i[c_idx];
  assign c_hit  = c_st != ST_I && tag_i[c_idx] == c_tag;
  assign accept = state_q == FS_IDLE && cpu_req_i && !ready_q && !snp_valid_i;
  assign local_ok = c_hit && (!cpu_we_i || c_st == ST_M || c_st == ST_E);
  assign evict  = !c_hit && c_st == ST_M;

  assign r_idx  = addr_q[IDX_W-1:0];
  assign r_tag  = addr_q[ADDR_W-1:IDX_W];
  assign r_hit  = st_i[r_idx] != ST_I && tag_i[r_idx] == r_tag;

  assign bus_req_o  = state_q == FS_REQ;
  assign bus_addr_o = addr_q;
  assign done       = bus_req_o && bus_gnt_i;

  // command follows the line state at grant time (R11)
  always_comb begin
    if (!bus_req_o)          bus_cmd_o = CMD_NONE;
    else if (we_q && r_hit)  bus_cmd_o = CMD_INV;
    else if (we_q)           bus_cmd_o = CMD_RDX;
    else                     bus_cmd_o = CMD_RD;
  end

  always_comb begin
    fill_we_o   = 1'b0;
    fill_idx_o  = c_idx;
    fill_st_o   = ST_I;
    fill_tag_o  = c_tag;
    fill_data_o = cpu_wdata_i;
    if (accept) begin
      if (local_ok && cpu_we_i) begin
        fill_we_o = 1'b1;
        fill_st_o = ST_M;
      end else if (evict) begin
        fill_we_o   = 1'b1;
        fill_tag_o  = tag_i[c_idx];
        fill_data_o = data_i[c_idx];
      end
    end
    if (done) begin
      fill_we_o  = 1'b1;
      fill_idx_o = r_idx;
      fill_tag_o = r_tag;
      if (we_q) begin
        fill_st_o   = ST_M;
        fill_data_o = wdata_q;
      end else begin
        fill_st_o   = bus_shared_i ? ST_S : ST_E;
        fill_data_o = bus_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= FS_IDLE;
      we_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      ready_q   <= 1'b0;
      rdata_q   <= '0;
      wb_q      <= 1'b0;
      wb_addr_q <= '0;
      wb_data_q <= '0;
    end else begin
      ready_q   <= 1'b0;
      wb_q      <= snp_wb_i;
      wb_addr_q <= snp_wb_addr_i;
      wb_data_q <= snp_wb_data_i;
      if (accept) begin
        we_q    <= cpu_we_i;
        addr_q  <= cpu_addr_i;
        wdata_q <= cpu_wdata_i;
        if (local_ok) begin
          ready_q <= 1'b1;
          rdata_q <= cpu_we_i ? cpu_wdata_i : data_i[c_idx];
        end else begin
          state_q <= FS_REQ;
          if (evict) begin
            wb_q      <= 1'b1;
            wb_addr_q <= {tag_i[c_idx], c_idx};
            wb_data_q <= data_i[c_idx];
          end
        end
      end
      if (done) begin
        state_q <= FS_IDLE;
        ready_q <= 1'b1;
        rdata_q <= we_q ? wdata_q : bus_data_i;
      end
    end
  end

  assign cpu_ready_o = ready_q;
  assign cpu_rdata_o = rdata_q;
  assign wb_valid_o  = wb_q;
  assign wb_addr_o   = wb_addr_q;
  assign wb_data_o   = wb_data_q;

  // R2: read fill state follows the shared response
  a_r2_fill_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && bus_cmd_o == CMD_RD |=>
      st_i[$past(r_idx)] == ($past(bus_shared_i) ? ST_S : ST_E));
  // R5: invalidate grant ends Modified
  a_r5_inv_to_m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && bus_cmd_o == CMD_INV |=> st_i[$past(r_idx)] == ST_M);
  // R6: Exclusive write hit stays off the bus
  a_r6_e_write_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && cpu_we_i && c_hit && c_st == ST_E |=> cpu_ready_o && !bus_req_o);
  // R9: Modified write hit stays off the bus
  a_r9_m_write_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && cpu_we_i && c_hit && c_st == ST_M |=> cpu_ready_o && !bus_req_o && !wb_valid_o);
  // R4/R8: dirty snoop hit produces a write-back
  a_r8_snoop_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_wb_i |=> wb_valid_o);
  // R12: pending request holds
  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_addr_o));
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int N_LINES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_shared_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_supply_o,
  output logic [DATA_W-1:0] snp_data_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o
);
  localparam int IDX_W = $clog2(N_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  mesi_e [N_LINES-1:0]             st;
  logic  [N_LINES-1:0][TAG_W-1:0]  tag;
  logic  [N_LINES-1:0][DATA_W-1:0] data;

  logic              fill_we, snp_we, snp_wb;
  logic [IDX_W-1:0]  fill_idx, snp_idx;
  mesi_e             fill_st, snp_st;
  logic [TAG_W-1:0]  fill_tag;
  logic [DATA_W-1:0] fill_data, snp_wb_data;
  logic [ADDR_W-1:0] snp_wb_addr;
  bus_cmd_e          own_cmd;

  mesi_line_store #(.N_LINES(N_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .fill_we_i(fill_we), .fill_idx_i(fill_idx), .fill_st_i(fill_st),
    .fill_tag_i(fill_tag), .fill_data_i(fill_data),
    .snp_we_i(snp_we), .snp_idx_i(snp_idx), .snp_st_i(snp_st),
    .st_o(st), .tag_o(tag), .data_o(data)
  );

  mesi_snoop_unit #(.N_LINES(N_LINES), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
                    .DATA_W(DATA_W)) u_snoop (
    .clk_i, .rst_ni,
    .snp_valid_i, .snp_cmd_i(bus_cmd_e'(snp_cmd_i)), .snp_addr_i,
    .st_i(st), .tag_i(tag), .data_i(data),
    .shared_o(snp_shared_o), .supply_o(snp_supply_o), .data_o(snp_data_o),
    .st_we_o(snp_we), .st_idx_o(snp_idx), .st_new_o(snp_st),
    .wb_o(snp_wb), .wb_addr_o(snp_wb_addr), .wb_data_o(snp_wb_data)
  );

  mesi_cpu_fsm #(.N_LINES(N_LINES), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
                 .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .snp_valid_i, .bus_gnt_i, .bus_shared_i, .bus_data_i,
    .st_i(st), .tag_i(tag), .data_i(data),
    .snp_wb_i(snp_wb), .snp_wb_addr_i(snp_wb_addr), .snp_wb_data_i(snp_wb_data),
    .cpu_ready_o, .cpu_rdata_o,
    .bus_req_o, .bus_cmd_o(own_cmd), .bus_addr_o,
    .wb_valid_o, .wb_addr_o, .wb_data_o,
    .fill_we_o(fill_we), .fill_idx_o(fill_idx), .fill_st_o(fill_st),
    .fill_tag_o(fill_tag), .fill_data_o(fill_data)
  );

  assign bus_cmd_o = own_cmd;
endmodule

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] C_NONE = 2'b00, C_RD = 2'b01, C_RDX = 2'b10, C_INV = 2'b11;

  logic        clk = 0, rst_n = 0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [7:0]  cpu_addr = 0;
  logic [15:0] cpu_wdata = 0;
  logic        cpu_ready;
  logic [15:0] cpu_rdata;
  logic        bus_req, bus_gnt = 0, bus_shared = 0;
  logic [1:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [15:0] bus_data = 0;
  logic        snp_valid = 0;
  logic [1:0]  snp_cmd = 0;
  logic [7:0]  snp_addr = 0;
  logic        snp_shared, snp_supply, wb_valid;
  logic [15:0] snp_data, wb_data;
  logic [7:0]  wb_addr;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  string       rd_tag_q[$];
  bit          mon_rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesi_line_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_data_i(bus_data), .bus_shared_i(bus_shared),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_shared_o(snp_shared), .snp_supply_o(snp_supply), .snp_data_o(snp_data),
    .wb_valid_o(wb_valid), .wb_addr_o(wb_addr), .wb_data_o(wb_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (cpu_ready && mon_rd && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = rd_tag_q.pop_front();
      chk(cpu_rdata == e, t, {16'h0, cpu_rdata}, {16'h0, e});
    end
  end

  task automatic cpu_op(input bit we, input logic [7:0] a, input logic [15:0] wd,
                        input logic [1:0] e_cmd, input bit shr, input logic [15:0] fill,
                        input logic [15:0] e_rd, input bit e_wb, input logic [7:0] e_wba,
                        input logic [15:0] e_wbd, input string req);
    logic [1:0]  seen_cmd;
    bit          seen_wb, got;
    logic [7:0]  s_wba;
    logic [15:0] s_wbd;
    seen_cmd = C_NONE; seen_wb = 0; got = 0; s_wba = 0; s_wbd = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    mon_rd = !we;
    if (!we) begin
      exp_q.push_back(e_rd);
      rd_tag_q.push_back({req, " rdata"});
    end
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (wb_valid) begin seen_wb = 1; s_wba = wb_addr; s_wbd = wb_data; end
      if (bus_req && !bus_gnt) begin
        seen_cmd = bus_cmd; bus_gnt = 1; bus_shared = shr; bus_data = fill;
      end else begin
        bus_gnt = 0;
      end
      if (cpu_ready) begin got = 1; break; end
    end
    cpu_req = 0; bus_gnt = 0;
    chk(got, {req, " completion"}, {31'h0, got}, 32'h1);
    chk(seen_cmd == e_cmd, {req, " bus command"}, {30'h0, seen_cmd}, {30'h0, e_cmd});
    chk(seen_wb == e_wb, {req, " write-back"}, {31'h0, seen_wb}, {31'h0, e_wb});
    if (e_wb) chk(s_wba == e_wba && s_wbd == e_wbd, {req, " write-back addr/data"},
                  {8'h0, s_wba, s_wbd}, {8'h0, e_wba, e_wbd});
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a, input bit e_shr,
                       input bit e_sup, input logic [15:0] e_data, input bit e_wb,
                       input logic [15:0] e_wbd, input string req);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #1;
    chk(snp_shared == e_shr, {req, " shared"}, {31'h0, snp_shared}, {31'h0, e_shr});
    chk(snp_supply == e_sup, {req, " supply"}, {31'h0, snp_supply}, {31'h0, e_sup});
    if (e_sup) chk(snp_data == e_data, {req, " supplied data"}, {16'h0, snp_data}, {16'h0, e_data});
    @(negedge clk);
    snp_valid = 0;
    chk(wb_valid == e_wb, {req, " write-back"}, {31'h0, wb_valid}, {31'h0, e_wb});
    if (e_wb) chk(wb_data == e_wbd && wb_addr == a, {req, " write-back addr/data"},
                  {8'h0, wb_addr, wb_data}, {8'h0, a, e_wbd});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_req && !cpu_ready && !wb_valid, "R1 reset outputs",
        {29'h0, bus_req, cpu_ready, wb_valid}, 0);
    for (int i = 0; i < 4; i++)
      snoop(C_RD, 8'h10 + 8'(i), 0, 0, 0, 0, 0, "R1 invalid after reset");

    // read miss, no sharer -> Exclusive
    cpu_op(0, 8'h04, 0, C_RD, 0, 16'h1111, 16'h1111, 0, 0, 0, "R2 read miss exclusive");
    cpu_op(1, 8'h04, 16'hAAAA, C_NONE, 0, 0, 0, 0, 0, 0, "R6 write exclusive");
    snoop(C_RD, 8'h04, 1, 1, 16'hAAAA, 1, 16'hAAAA, "R4 snoop read modified");
    cpu_op(1, 8'h04, 16'hBBBB, C_INV, 0, 0, 0, 0, 0, 0, "R5 write shared");
    cpu_op(1, 8'h04, 16'hCCCC, C_NONE, 0, 0, 0, 0, 0, 0, "R9 write modified");
    snoop(C_INV, 8'h04, 0, 0, 0, 1, 16'hCCCC, "R8 snoop invalidate modified");
    cpu_op(0, 8'h04, 0, C_RD, 1, 16'h2222, 16'h2222, 0, 0, 0, "R7 line invalid; R2 shared fill");
    snoop(C_RD, 8'h04, 1, 1, 16'h2222, 0, 0, "R3 snoop read shared");
    cpu_op(0, 8'h04, 0, C_NONE, 0, 0, 16'h2222, 0, 0, 0, "R3 read hit after snoop");

    // write miss
    cpu_op(1, 8'h09, 16'h5555, C_RDX, 0, 16'h0F0F, 0, 0, 0, 0, "R10 write miss");
    cpu_op(0, 8'h09, 0, C_NONE, 0, 0, 16'h5555, 0, 0, 0, "R10 data after write miss");
    snoop(C_RDX, 8'h09, 0, 1, 16'h5555, 1, 16'h5555, "R7 R8 snoop rdx modified");
    snoop(C_RD, 8'h09, 0, 0, 0, 0, 0, "R7 gone after rdx");

    // exclusive line snooped read -> shared, no write-back
    cpu_op(0, 8'h03, 0, C_RD, 0, 16'h3333, 16'h3333, 0, 0, 0, "R2 fill for R3");
    snoop(C_RD, 8'h03, 1, 1, 16'h3333, 0, 0, "R3 snoop read exclusive");
    cpu_op(1, 8'h03, 16'h3434, C_INV, 0, 0, 0, 0, 0, 0, "R3 line now shared");

    // dirty victim eviction
    cpu_op(0, 8'h02, 0, C_RD, 0, 16'h7777, 16'h7777, 0, 0, 0, "R2 fill victim");
    cpu_op(1, 8'h02, 16'h8888, C_NONE, 0, 0, 0, 0, 0, 0, "R6 dirty victim");
    cpu_op(0, 8'h06, 0, C_RD, 0, 16'h9999, 16'h9999, 1, 8'h02, 16'h8888, "R12 evict dirty victim");
    snoop(C_RD, 8'h02, 0, 0, 0, 0, 0, "R12 old tag gone");

    // race: line 0x04 Shared, write waits, snoop invalidates it meanwhile
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h04; cpu_wdata = 16'hDDDD; mon_rd = 0;
    @(negedge clk);
    chk(bus_req && bus_cmd == C_INV, "R11 pending invalidate", {30'h0, bus_cmd}, {30'h0, C_INV});
    snp_valid = 1; snp_cmd = C_INV; snp_addr = 8'h04;
    @(negedge clk);
    snp_valid = 0;
    chk(bus_req && bus_addr == 8'h04, "R12 request held", {23'h0, bus_req, bus_addr}, {23'h1, 8'h04});
    chk(bus_cmd == C_RDX, "R11 switched to rdx", {30'h0, bus_cmd}, {30'h0, C_RDX});
    bus_gnt = 1; bus_data = 16'h4444; bus_shared = 0;
    @(negedge clk);
    bus_gnt = 0; cpu_req = 0;
    chk(cpu_ready, "R11 write done", {31'h0, cpu_ready}, 1);
    cpu_op(0, 8'h04, 0, C_NONE, 0, 0, 16'hDDDD, 0, 0, 0, "R11 line holds write data");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule